// File: doc/BRIEF.md
# 64-bit XGMII Transmit Framer

This block turns a stream of 64-bit frame words, taken from a first-word-fall-through queue, into the character stream of a 64-bit XGMII transmit interface. Each clock it drives one eight-lane data word and a matching per-lane control mask. While nothing is queued, it fills the line with idle characters.

When the queue reports valid data, the framer first emits a start word. That word carries the start control character followed by preamble bytes and the frame delimiter. Next it pulls payload words one per clock and passes each one on with its byte order mirrored. When the queue runs dry it closes the frame with a terminate character. No check sequence is inserted and no gap is enforced, so a new frame may open directly after the terminate cycle.

Every output is registered. A word on the bus is always caused by the inputs seen at the previous rising edge. A word is consumed from the queue at any rising edge where the pull output and the valid input are both high.

Top module: `xgmii_tx_framer`

## Requirements
- R1: While the synchronous active-high reset is high, the next bus word is idle (0x07 in every lane, all control bits 1) and the pull output is low, whatever the valid input does.
- R2: While the framer is idle and valid is low, every following word is idle, with all control bits 1 and pull low.
- R3: When valid is high at an edge where the bus shows an idle word, the next word is a start word. That word has 0xFB in lane 0 (bits 7:0), 0x55 in lanes 1 to LANES-2, and 0xD5 in the top lane. Its control mask has only bit 0 set, and pull is high in that cycle.
- R4: A queued word accepted at an edge (pull and valid both high) appears on the bus in the next cycle with its lanes reversed, so output lane i carries input lane LANES-1-i. The control mask is all 0. Example: 0x0123456789ABCDEF leaves as 0xEFCDAB8967452301.
- R5: While valid stays high, pull stays high, and consecutive queued words leave on consecutive cycles with no gap.
- R6: When valid is low at an edge during a payload cycle, the next word is a terminate word, with 0xFD in lane 0, 0x07 in every other lane, all control bits 1 and pull low. Nothing is inserted between the last payload word and this terminate word.
- R7: When valid is high during a terminate cycle, the very next word is a start word, with no idle word in between.
- R8: When valid falls during the start-word cycle, the next word is a terminate word with pull low, which closes an empty frame.
- R9: Pull is high exactly in the cycles whose control mask is not all ones, which are the start and payload cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| src_data | input | LANES*8 | Head word of the frame queue |
| src_valid | input | 1 | Queue holds a word for the current frame |
| pull | output | 1 | Registered read strobe; a word is taken when this and src_valid are high at an edge |
| txd | output | LANES*8 | Registered XGMII transmit data, lane 0 in bits 7:0 |
| txc | output | LANES | Registered per-lane control mask, 1 marks a control character |

## Verification
The bench builds the framer with its default eight lanes, which is the width the start-word layout and the lane reversal are specified for. Within that configuration it sweeps frame lengths from zero to five payload words against idle gaps of zero to three cycles. The sweep therefore reaches empty frames, single-word frames, back-to-back frames that restart in the terminate cycle, and long idle runs. Each payload word is an arithmetic pattern built from its frame and word index, so any lane mapped to the wrong position shows up as a mismatch.

// File: rtl/xtx_pkg.sv
package xtx_pkg;
  localparam logic [7:0] CH_IDLE  = 8'h07;
  localparam logic [7:0] CH_START = 8'hFB;
  localparam logic [7:0] CH_TERM  = 8'hFD;
  localparam logic [7:0] CH_PRE   = 8'h55;
  localparam logic [7:0] CH_SFD   = 8'hD5;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2
  } xtx_state_e;
endpackage

// File: rtl/xtx_ctrl_words.sv
module xtx_ctrl_words
  import xtx_pkg::*;
#(
  parameter int LANES = 8
) (
  output logic [LANES*8-1:0] idle_word,
  output logic [LANES*8-1:0] start_word,
  output logic [LANES*8-1:0] term_word
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign idle_word[l*8 +: 8] = CH_IDLE;
    if (l == 0) begin : g_first
      assign start_word[l*8 +: 8] = CH_START;
      assign term_word[l*8 +: 8]  = CH_TERM;
    end else if (l == LANES-1) begin : g_last
      assign start_word[l*8 +: 8] = CH_SFD;
      assign term_word[l*8 +: 8]  = CH_IDLE;
    end else begin : g_mid
      assign start_word[l*8 +: 8] = CH_PRE;
      assign term_word[l*8 +: 8]  = CH_IDLE;
    end
  end
endmodule

// File: rtl/xtx_byte_rev.sv
module xtx_byte_rev #(
  parameter int LANES = 8
) (
  input  logic [LANES*8-1:0] din,
  output logic [LANES*8-1:0] dout
);
  for (genvar l = 0; l < LANES; l++) begin : g_swap
    assign dout[l*8 +: 8] = din[(LANES-1-l)*8 +: 8];
  end
endmodule

// File: rtl/xtx_seq.sv
module xtx_seq
  import xtx_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               src_valid,
  input  logic [LANES*8-1:0] payload,
  input  logic [LANES*8-1:0] idle_word,
  input  logic [LANES*8-1:0] start_word,
  input  logic [LANES*8-1:0] term_word,
  output logic               pull,
  output logic [LANES*8-1:0] txd,
  output logic [LANES-1:0]   txc
);
  localparam logic [LANES-1:0] CTL_ALL   = '1;
  localparam logic [LANES-1:0] CTL_NONE  = '0;
  localparam logic [LANES-1:0] CTL_LANE0 = LANES'(1);

  xtx_state_e         state, state_n;
  logic [LANES*8-1:0] txd_n;
  logic [LANES-1:0]   txc_n;
  logic               pull_n;

  always_comb begin
    state_n = ST_IDLE;
    txd_n   = idle_word;
    txc_n   = CTL_ALL;
    pull_n  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (src_valid) begin
          state_n = ST_START;
          txd_n   = start_word;
          txc_n   = CTL_LANE0;
          pull_n  = 1'b1;
        end
      end
      ST_START, ST_DATA: begin
        if (src_valid) begin
          state_n = ST_DATA;
          txd_n   = payload;
          txc_n   = CTL_NONE;
          pull_n  = 1'b1;
        end else begin
          txd_n   = term_word;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      txd   <= idle_word;
      txc   <= CTL_ALL;
      pull  <= 1'b0;
    end else begin
      state <= state_n;
      txd   <= txd_n;
      txc   <= txc_n;
      pull  <= pull_n;
    end
  end
endmodule

// File: rtl/xgmii_tx_framer.sv
module xgmii_tx_framer #(
  parameter int LANES = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [LANES*8-1:0] src_data,
  input  logic               src_valid,
  output logic               pull,
  output logic [LANES*8-1:0] txd,
  output logic [LANES-1:0]   txc
);
  localparam int DW = LANES * 8;

  logic [DW-1:0] idle_w, start_w, term_w, swapped;

  xtx_ctrl_words #(.LANES(LANES)) u_words (
    .idle_word  (idle_w),
    .start_word (start_w),
    .term_word  (term_w)
  );

  xtx_byte_rev #(.LANES(LANES)) u_rev (
    .din  (src_data),
    .dout (swapped)
  );

  xtx_seq #(.LANES(LANES)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .src_valid  (src_valid),
    .payload    (swapped),
    .idle_word  (idle_w),
    .start_word (start_w),
    .term_word  (term_w),
    .pull       (pull),
    .txd        (txd),
    .txc        (txc)
  );
endmodule

// File: rtl/xtx_chk.sv
module xtx_chk #(
  parameter int LANES = 8
) (
  input logic               clk,
  input logic               rst,
  input logic [LANES*8-1:0] src_data,
  input logic               src_valid,
  input logic               pull,
  input logic [LANES*8-1:0] txd,
  input logic [LANES-1:0]   txc
);
  localparam logic [LANES-1:0] ALL1 = '1;

  function automatic logic [LANES*8-1:0] mirror(input logic [LANES*8-1:0] w);
    logic [LANES*8-1:0] r;
    for (int i = 0; i < LANES; i++) r[i*8 +: 8] = w[(LANES-1-i)*8 +: 8];
    return r;
  endfunction

  function automatic logic [LANES*8-1:0] idles();
    logic [LANES*8-1:0] r;
    for (int i = 0; i < LANES; i++) r[i*8 +: 8] = 8'h07;
    return r;
  endfunction

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (txc == ALL1 && txd == idles() && !pull));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!pull && !src_valid) |=> (txc == ALL1 && txd == idles() && !pull));

  // R3
  start_word_chk: assert property (@(posedge clk) disable iff (rst)
    (!pull && src_valid) |=> (txc == LANES'(1) && txd[7:0] == 8'hFB
                              && txd[LANES*8-1 -: 8] == 8'hD5 && pull));

  // R4
  payload_swap_chk: assert property (@(posedge clk) disable iff (rst)
    (pull && src_valid) |=> (txc == '0 && txd == mirror($past(src_data)) && pull));

  // R6
  terminate_chk: assert property (@(posedge clk) disable iff (rst)
    (pull && !src_valid) |=> (txc == ALL1 && txd[7:0] == 8'hFD && !pull));

  // R9
  pull_mask_chk: assert property (@(posedge clk) disable iff (rst)
    pull == (txc != ALL1));
endmodule

bind xgmii_tx_framer xtx_chk #(.LANES(LANES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .src_data  (src_data),
  .src_valid (src_valid),
  .pull      (pull),
  .txd       (txd),
  .txc       (txc)
);

// File: tb/xgmii_tx_framer_tb.sv
module xgmii_tx_framer_tb;
  localparam int LANES = 8;
  localparam int DW    = LANES * 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] src_data = '0;
  logic          src_valid = 1'b0;
  logic          pull;
  logic [DW-1:0] txd;
  logic [LANES-1:0] txc;

  int n_chk = 0;
  int n_bad = 0;
  int m_st  = 0;      // 0 idle/term on bus, 1 start, 2 payload
  bit m_term = 1'b0;

  always #10 clk = ~clk;

  xgmii_tx_framer #(.LANES(LANES)) u_dut (
    .clk(clk), .rst(rst), .src_data(src_data), .src_valid(src_valid),
    .pull(pull), .txd(txd), .txc(txc)
  );

  function automatic logic [DW-1:0] fill(input logic [7:0] b);
    logic [DW-1:0] r;
    for (int i = 0; i < LANES; i++) r[i*8 +: 8] = b;
    return r;
  endfunction

  function automatic logic [DW-1:0] start_exp();
    logic [DW-1:0] r = fill(8'h55);
    r[7:0] = 8'hFB;
    r[DW-1 -: 8] = 8'hD5;
    return r;
  endfunction

  function automatic logic [DW-1:0] term_exp();
    logic [DW-1:0] r = fill(8'h07);
    r[7:0] = 8'hFD;
    return r;
  endfunction

  function automatic logic [DW-1:0] swap_exp(input logic [DW-1:0] w);
    logic [DW-1:0] r;
    for (int i = 0; i < LANES; i++) r[i*8 +: 8] = w[(LANES-1-i)*8 +: 8];
    return r;
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] ed,
                       input logic [LANES-1:0] ec, input logic ep);
    n_chk++;
    if (txd !== ed || txc !== ec) begin
      n_bad++;
      $display("FAIL %s: txd=%h txc=%b expected txd=%h txc=%b", tag, txd, txc, ed, ec);
    end
    n_chk++;
    if (pull !== ep) begin
      n_bad++;
      $display("FAIL R9 (%s): pull=%b expected %b", tag, pull, ep);
    end
  endtask

  task automatic step(input logic v, input logic [DW-1:0] d);
    logic [DW-1:0] ed;
    logic [LANES-1:0] ec;
    logic ep;
    string tag;
    @(negedge clk);
    src_valid = v;
    src_data  = d;
    if (m_st == 0) begin
      if (v) begin
        ed = start_exp(); ec = LANES'(1); ep = 1'b1;
        tag = m_term ? "R7" : "R3"; m_st = 1;
      end else begin
        ed = fill(8'h07); ec = '1; ep = 1'b0; tag = "R2";
      end
      m_term = 1'b0;
    end else if (v) begin
      ed = swap_exp(d); ec = '0; ep = 1'b1;
      tag = (m_st == 2) ? "R5" : "R4"; m_st = 2;
    end else begin
      ed = term_exp(); ec = '1; ep = 1'b0;
      tag = (m_st == 1) ? "R8" : "R6"; m_st = 0; m_term = 1'b1;
    end
    @(posedge clk);
    #1;
    check(tag, ed, ec, ep);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1: reset holds idle even with valid high
    src_valid = 1'b1;
    src_data  = 64'h0123456789ABCDEF;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      check("R1", fill(8'h07), '1, 1'b0);
    end
    @(negedge clk);
    rst = 1'b0;
    src_valid = 1'b0;
    step(1'b0, '0);
    step(1'b0, '0);

    // R4 worked example from the requirement
    step(1'b1, 64'h0123456789ABCDEF);
    step(1'b1, 64'h0123456789ABCDEF);
    n_chk++;
    if (txd !== 64'hEFCDAB8967452301) begin
      n_bad++;
      $display("FAIL R4: txd=%h expected %h", txd, 64'hEFCDAB8967452301);
    end
    step(1'b0, '0);

    // sweep frame length x idle gap
    for (int len = 0; len <= 5; len++) begin
      for (int gap = 0; gap <= 3; gap++) begin
        for (int k = 0; k <= len; k++) begin
          logic [DW-1:0] w;
          int idx = (k == 0) ? 0 : k - 1;
          w = (64'h0123_4567_89AB_CDEF ^ (64'(len * 4 + gap) << 40))
              + 64'(idx) * 64'h1111_1111_1111_1111;
          step(1'b1, w);
        end
        step(1'b0, '0);
        for (int g = 0; g < gap; g++) step(1'b0, '0);
      end
    end
    step(1'b0, '0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule